// File: doc/BRIEF.md
# Filtered Fault Shutdown for Three-Phase Gate Drive

This stage sits between a three-phase PWM generator and the six gate-drive pins of an inverter bridge, with a seventh lane for the power-factor-correction (PFC) switch. Each lane receives a logical command, where 1 means the switch is on. Each lane then presents that command at a polarity chosen per output. An asynchronous motor fault input is brought into the clock domain by two flops. It then passes through a qualification counter that must see the fault level without a break before it acts. A qualified fault sets a shutdown latch. While the latch is set, all six phase outputs sit at their inactive level.

The PFC lane has a dedicated fault input that is filtered the same way and has its own latch. When the dedicated pin is handed over to other use (`pfc_follow` = 1), that pin is ignored and the motor shutdown also drives the PFC output inactive. A latch is released only by a software clear pulse, and only while its own synchronized fault is inactive.

The filter length is an input in system clocks. A value of 100 at a 50 MHz clock gives the usual 2 µs qualification. Lengths below 31 are raised to 31, so a pulse shorter than 32 clocks can never cause a shutdown. The PWM lanes carry no handshake: they are level signals that pass through combinationally, so there is no back-pressure.

Top module: `gk_shutdown`

## Requirements
- R1: After reset, both latches are clear and every output follows its command.
- R2: `mot_fault_pol` selects the active level of `mot_fault`: 1 for high-true, 0 for low-true. The inactive level never starts a shutdown.
- R3: Let Le = max(`filt_len`, 31). A motor fault present on Le+1 consecutive rising edges sets the shutdown. The phase outputs are inactive from the (Le+3)th rising edge after the fault first appears. A pulse seen on fewer edges has no effect.
- R4: A single edge at which the fault is inactive restarts qualification from zero.
- R5: While shutdown is set, `phase_out[i]` equals `~out_pol[i]`. Bit i of `out_pol` = 1 means output i is active-high.
- R6: Shutdown stays set after the fault goes away.
- R7: A clear pulse releases a latch at the next edge only if that latch's synchronized fault is inactive. A clear while the fault is active, including at the edge where qualification completes, is lost.
- R8: With `pfc_follow` = 1, a motor shutdown also drives `pfc_out` to `~pfc_pol`, and `pfc_fault` is ignored.
- R9: With `pfc_follow` = 0, a qualified `pfc_fault` (polarity set by `pfc_fault_pol`, same filter length) drives only `pfc_out` inactive. A motor shutdown leaves `pfc_out` alone.
- R10: When not shut down, each output equals its polarity bit if its command is 1, and the inverse of that bit if its command is 0, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mot_fault | input | 1 | Asynchronous motor fault |
| mot_fault_pol | input | 1 | Active level of mot_fault |
| pfc_fault | input | 1 | Asynchronous dedicated PFC fault |
| pfc_fault_pol | input | 1 | Active level of pfc_fault |
| pfc_follow | input | 1 | 1: motor shutdown also kills PFC, pfc_fault ignored |
| filt_len | input | CNT_W | Qualification length in clocks (minimum 31 applied) |
| clear | input | 1 | Software release pulse |
| phase_in | input | N_PH | Phase commands (1 = on) |
| pfc_in | input | 1 | PFC command (1 = on) |
| out_pol | input | N_PH | Per-phase active level |
| pfc_pol | input | 1 | PFC active level |
| phase_out | output | N_PH | Gate-drive phase outputs |
| pfc_out | output | 1 | Gate-drive PFC output |

## Verification
A clear pulse and the completion of qualification can meet at the same edge. The bench holds the fault for exactly the qualifying length and raises `clear` for the edge at which the count completes. It expects the outputs to stay forced, because the still-active fault blocks the release. A second coincidence comes from driving the motor fault and the dedicated PFC fault together, with `pfc_follow` set each way. Each lane is then judged against the route the mode selects.

// File: rtl/gk_pkg.sv
package gk_pkg;
  // smallest qualification length; pulses must span GK_MIN_QUAL+1 edges
  localparam int unsigned GK_MIN_QUAL = 31;

  typedef struct packed {
    logic active;  // synchronized fault at its active level
    logic hit;     // qualification complete this cycle
  } gk_flt_t;
endpackage

// File: rtl/gk_sync_filter.sv
module gk_sync_filter
  import gk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic             act_high,
  input  logic [CNT_W-1:0] len,
  output gk_flt_t          st
);
  localparam logic [CNT_W-1:0] MIN_L = CNT_W'(GK_MIN_QUAL);

  logic             s1, s2;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff_len;

  assign eff_len = (len < MIN_L) ? MIN_L : len;

  // the level is folded into "active" before the first flop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= (raw == act_high);
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!s2)           cnt <= '0;
    else if (cnt < eff_len) cnt <= cnt + 1'b1;
  end

  assign st.active = s2;
  assign st.hit    = s2 && (cnt >= eff_len);
endmodule

// File: rtl/gk_kill_latch.sv
module gk_kill_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_req,
  input  logic src_active,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      q <= 1'b0;
    else if (set)                    q <= 1'b1;
    else if (clr_req && !src_active) q <= 1'b0;
  end
endmodule

// File: rtl/gk_out_mask.sv
module gk_out_mask #(
  parameter int N = 7
) (
  input  logic [N-1:0] cmd,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] kill,
  output logic [N-1:0] drv
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    always_comb begin
      if (kill[i]) drv[i] = ~pol[i];
      else         drv[i] = cmd[i] ? pol[i] : ~pol[i];
    end
  end
endmodule

// File: rtl/gk_shutdown.sv
module gk_shutdown
  import gk_pkg::*;
#(
  parameter int N_PH  = 6,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mot_fault,
  input  logic             mot_fault_pol,
  input  logic             pfc_fault,
  input  logic             pfc_fault_pol,
  input  logic             pfc_follow,
  input  logic [CNT_W-1:0] filt_len,
  input  logic             clear,
  input  logic [N_PH-1:0]  phase_in,
  input  logic             pfc_in,
  input  logic [N_PH-1:0]  out_pol,
  input  logic             pfc_pol,
  output logic [N_PH-1:0]  phase_out,
  output logic             pfc_out
);
  localparam int NL = N_PH + 1;

  gk_flt_t m_st, p_st;
  logic    mot_kill, pfc_lat, pfc_kill;
  logic    m_hit, m_active;
  logic [NL-1:0] lane_drv;

  gk_sync_filter #(.CNT_W(CNT_W)) u_mflt (
    .clk(clk), .rst_n(rst_n), .raw(mot_fault), .act_high(mot_fault_pol),
    .len(filt_len), .st(m_st));

  gk_sync_filter #(.CNT_W(CNT_W)) u_pflt (
    .clk(clk), .rst_n(rst_n), .raw(pfc_fault), .act_high(pfc_fault_pol),
    .len(filt_len), .st(p_st));

  assign m_hit    = m_st.hit;
  assign m_active = m_st.active;

  gk_kill_latch u_mlat (
    .clk(clk), .rst_n(rst_n), .set(m_hit), .clr_req(clear),
    .src_active(m_active), .q(mot_kill));

  gk_kill_latch u_plat (
    .clk(clk), .rst_n(rst_n), .set(p_st.hit && !pfc_follow), .clr_req(clear),
    .src_active(p_st.active), .q(pfc_lat));

  assign pfc_kill = pfc_lat || (pfc_follow && mot_kill);

  gk_out_mask #(.N(NL)) u_mask (
    .cmd ({pfc_in, phase_in}),
    .pol ({pfc_pol, out_pol}),
    .kill({pfc_kill, {N_PH{mot_kill}}}),
    .drv (lane_drv));

  assign phase_out = lane_drv[N_PH-1:0];
  assign pfc_out   = lane_drv[NL-1];
endmodule

// File: rtl/gk_shutdown_chk.sv
module gk_shutdown_chk #(
  parameter int N_PH = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clear,
  input logic            pfc_follow,
  input logic [N_PH-1:0] phase_in,
  input logic [N_PH-1:0] out_pol,
  input logic            pfc_pol,
  input logic [N_PH-1:0] phase_out,
  input logic            pfc_out,
  input logic            mot_kill,
  input logic            m_hit,
  input logic            m_active
);
  p_kill_forces_phases_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mot_kill |-> phase_out == ~out_pol);

  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mot_kill && !clear |=> mot_kill);

  p_clear_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mot_kill && m_active |=> mot_kill);

  p_set_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mot_kill) |-> $past(m_hit));

  p_pfc_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pfc_follow && mot_kill |-> pfc_out == ~pfc_pol);

  p_pass_through_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mot_kill |-> phase_out == ~(phase_in ^ out_pol));
endmodule

bind gk_shutdown gk_shutdown_chk #(.N_PH(N_PH)) chk_i (
  .clk(clk), .rst_n(rst_n), .clear(clear), .pfc_follow(pfc_follow),
  .phase_in(phase_in), .out_pol(out_pol), .pfc_pol(pfc_pol),
  .phase_out(phase_out), .pfc_out(pfc_out), .mot_kill(mot_kill),
  .m_hit(m_hit), .m_active(m_active));

// File: tb/gk_shutdown_tb_top.sv
`timescale 1ns/1ps
module gk_shutdown_tb_top;
  localparam int N_PH  = 6;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic mot_fault, mot_fault_pol, pfc_fault, pfc_fault_pol, pfc_follow;
  logic [CNT_W-1:0] filt_len;
  logic clear, pfc_in, pfc_pol;
  logic [N_PH-1:0] phase_in, out_pol, phase_out;
  logic pfc_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gk_shutdown #(.N_PH(N_PH), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .mot_fault(mot_fault), .mot_fault_pol(mot_fault_pol),
    .pfc_fault(pfc_fault), .pfc_fault_pol(pfc_fault_pol), .pfc_follow(pfc_follow),
    .filt_len(filt_len), .clear(clear), .phase_in(phase_in), .pfc_in(pfc_in),
    .out_pol(out_pol), .pfc_pol(pfc_pol), .phase_out(phase_out), .pfc_out(pfc_out));

  function automatic logic [N_PH-1:0] exp_ph(logic [N_PH-1:0] c, logic [N_PH-1:0] p, bit k);
    return k ? ~p : ~(c ^ p);
  endfunction

  function automatic logic exp_pf(logic c, logic p, bit k);
    return k ? ~p : ~(c ^ p);
  endfunction

  task automatic chk_ph(string req, bit k);
    logic [N_PH-1:0] e;
    e = exp_ph(phase_in, out_pol, k);
    n_cmp++;
    if (phase_out !== e) begin
      n_bad++;
      $display("FAIL %s phase_out act=%b exp=%b", req, phase_out, e);
    end
  endtask

  task automatic chk_pf(string req, bit k);
    logic e;
    e = exp_pf(pfc_in, pfc_pol, k);
    n_cmp++;
    if (pfc_out !== e) begin
      n_bad++;
      $display("FAIL %s pfc_out act=%b exp=%b", req, pfc_out, e);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic mfault(bit on);
    mot_fault = on ? mot_fault_pol : ~mot_fault_pol;
  endtask

  task automatic pfault(bit on);
    pfc_fault = on ? pfc_fault_pol : ~pfc_fault_pol;
  endtask

  task automatic do_clear();
    clear = 1'b1;
    tick(1);
    clear = 1'b0;
  endtask

  task automatic settle_clear();
    mfault(0);
    pfault(0);
    tick(4);
    do_clear();
    tick(1);
  endtask

  task automatic rnd_cmd();
    phase_in = N_PH'($urandom);
    out_pol  = N_PH'($urandom);
    pfc_in   = 1'($urandom);
    pfc_pol  = 1'($urandom);
    #1;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; mot_fault_pol = 1'b1; pfc_fault_pol = 1'b1; pfc_follow = 1'b1;
    mot_fault = 1'b0; pfc_fault = 1'b0; filt_len = 16'd40; clear = 1'b0;
    phase_in = 6'b101010; out_pol = 6'b110011; pfc_in = 1'b1; pfc_pol = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk_ph("R1", 0);
    chk_pf("R1", 0);

    for (int i = 0; i < 16; i++) begin
      rnd_cmd();
      chk_ph("R10", 0);
      chk_pf("R10", 0);
    end

    // R3 exact edge, Le = 40
    mfault(1);
    tick(42);
    chk_ph("R3", 0);
    tick(1);
    chk_ph("R3", 1);
    for (int i = 0; i < 6; i++) begin
      rnd_cmd();
      chk_ph("R5", 1);
      chk_pf("R8", 1);
    end
    do_clear();
    chk_ph("R7", 1);
    mfault(0);
    tick(10);
    chk_ph("R6", 1);
    do_clear();
    chk_ph("R7", 0);

    // R4 gap restarts the count
    mfault(1); tick(30); mfault(0); tick(1); mfault(1); tick(30); mfault(0);
    tick(20);
    chk_ph("R4", 0);

    // R3 minimum length clamp: Le = 31
    filt_len = 16'd5;
    mfault(1); tick(31); mfault(0); tick(10);
    chk_ph("R3", 0);
    mfault(1); tick(33);
    chk_ph("R3", 0);
    tick(1);
    chk_ph("R3", 1);
    settle_clear();
    chk_ph("R7", 0);

    // R2 low-true motor fault
    filt_len = 16'd40;
    mot_fault_pol = 1'b0;
    mfault(0);
    tick(60);
    chk_ph("R2", 0);
    mfault(1);
    tick(43);
    chk_ph("R2", 1);
    settle_clear();
    mot_fault_pol = 1'b1;
    mfault(0);
    tick(4);
    chk_ph("R2", 0);

    // R9 dedicated PFC route
    pfc_follow = 1'b0;
    mfault(1); tick(45);
    chk_ph("R9", 1);
    chk_pf("R9", 0);
    settle_clear();
    pfault(1); tick(45);
    chk_pf("R9", 1);
    chk_ph("R9", 0);
    settle_clear();
    chk_pf("R9", 0);

    // R8 dedicated pin ignored when following
    pfc_follow = 1'b1;
    pfault(1); tick(50);
    chk_pf("R8", 0);
    chk_ph("R8", 0);
    pfault(0); tick(4);

    // R7 clear meets qualification at the same edge
    mfault(1); tick(42);
    clear = 1'b1; tick(1); clear = 1'b0;
    chk_ph("R7", 1);
    tick(3);
    chk_ph("R7", 1);
    settle_clear();
    chk_ph("R7", 0);

    // R3 random lengths around the threshold
    for (int i = 0; i < 12; i++) begin
      int le, m;
      bit ek;
      le = 31 + int'($urandom % 20);
      m  = le - 2 + int'($urandom % 5);
      filt_len = CNT_W'(le);
      rnd_cmd();
      ek = (m >= le + 1);
      mfault(1); tick(m); mfault(0);
      tick(le + 6);
      chk_ph("R3", ek);
      settle_clear();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule